// File: doc/BRIEF.md
# Reorder Buffer with In-Order Multi-Lane Commit

This block keeps up to sixteen in-flight instructions in program order while their results come back in any order. A dispatch port claims the slot at the tail of a circular queue and hands back that slot number as a tag. An execution unit later presents the tag together with its result. The buffer stores the result in that slot and marks the slot done.

Each cycle the oldest entries are inspected from the head. As many as four consecutive done entries are presented to the architectural register file through parallel write lanes, and they leave the queue at the clock edge. A small map, with one entry per logical register, records which slot will produce that register's next value. A consumer being dispatched can therefore name a pending slot rather than the register. A flush input throws away every speculative entry and every mapping in one cycle.

Top module: `reorder_buffer`

## Requirements
- R1: Dispatch returns the current tail slot as `disp_tag`. Tags go up by one per accepted dispatch and wrap from 15 to 0. After reset or flush the first tag is 0. A newly allocated slot is not done.
- R2: `disp_ready` is low while all 16 slots are held, and also during a flush cycle. `rob_full` is high exactly when 16 slots are held. A dispatch offered while `disp_ready` is low is ignored and allocates nothing.
- R3: A completion stores `cmpl_data` into the slot named by `cmpl_tag` and marks that slot done. Completions may arrive in any order. A slot completed at a clock edge can commit in the cycle that follows that edge.
- R4: Commit lane k (k = 0..3) carries the slot head+k, giving its destination register on `cmt_reg[3k+2:3k]` and its result on `cmt_data[16k+15:16k]`. Lanes fill in order from the head and stop at the first slot that is not done or not allocated. The presented entries retire at the next edge.
- R5: No more than 4 slots commit per cycle. The set bits of `cmt_valid` are always contiguous and start at bit 0.
- R6: An accepted dispatch maps its destination register to the new tag. A lookup reports `src_*_pend`=1 together with the tag of the youngest pending writer. A lookup made in the same cycle as a dispatch to that register still sees the previous mapping.
- R7: When a slot retires, its register mapping is cleared only if the mapping still points at that slot. A lookup of a register whose mapped slot is retiring in the current cycle reports not pending.
- R8: While `flush` is high, no commit lane is valid. The next cycle the buffer is empty, no register is mapped, and the next tag issued is 0.
- R9: After reset the buffer is empty and not full, `disp_ready` is 1, no commit lane is valid, and no lookup is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all speculative entries and mappings |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | 3 | Destination logical register of the dispatched instruction |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | 4 | Slot allocated to the dispatched instruction |
| src_a_reg | input | 3 | First source register to look up |
| src_a_pend | output | 1 | First source awaits a buffered result |
| src_a_tag | output | 4 | Slot that will produce the first source |
| src_b_reg | input | 3 | Second source register to look up |
| src_b_pend | output | 1 | Second source awaits a buffered result |
| src_b_tag | output | 4 | Slot that will produce the second source |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_tag | input | 4 | Slot being completed |
| cmpl_data | input | 16 | Result value |
| cmt_valid | output | 4 | Per-lane register file write enable |
| cmt_reg | output | 12 | Per-lane destination register, 3 bits per lane |
| cmt_data | output | 64 | Per-lane write data, 16 bits per lane |
| rob_empty | output | 1 | No slot held |
| rob_full | output | 1 | All slots held |

## Verification
Retirement and flush can both act in the same cycle. The bench provokes this by completing the two oldest slots and then raising `flush` in the very cycle in which they would otherwise commit. It judges the outcome by checking that every commit lane stays low, that dispatch is refused, and that on the following cycle the queue is empty, the map is clear and the tag sequence has restarted at zero. A second overlap is a map lookup made in the same cycle as the retirement of the slot it names; the bench expects not pending there, and still pending when a younger writer has already replaced the mapping.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ROB_DEPTH   = 16;
  localparam int ROB_LANES   = 4;
  localparam int ROB_NREG    = 8;
  localparam int ROB_DATA_W  = 16;

  // circular index arithmetic, valid for any depth
  function automatic int wrap_add(int base, int step, int depth);
    return (base + step) % depth;
  endfunction

  function automatic int count_bits(int value, int width);
    int n;
    n = 0;
    for (int i = 0; i < width; i++) n += (value >> i) & 1;
    return n;
  endfunction
endpackage

// File: rtl/rob_retire_scan.sv
module rob_retire_scan #(
  parameter int DEPTH = rob_pkg::ROB_DEPTH,
  parameter int LANES = rob_pkg::ROB_LANES,
  localparam int TW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int RNW  = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kill,
  input  logic [TW-1:0]       head,
  input  logic [CNTW-1:0]     count,
  input  logic [DEPTH-1:0]    done_vec,
  output logic [LANES-1:0]    lane_ok,
  output logic [LANES*TW-1:0] lane_idx,
  output logic [RNW-1:0]      retire_n
);
  logic          run;
  logic [TW-1:0] idx_a [LANES];

  always_comb begin
    run = !kill;
    for (int k = 0; k < LANES; k++) begin
      idx_a[k] = TW'(rob_pkg::wrap_add(int'(head), k, DEPTH));
      run = run && (int'(count) > k) && done_vec[idx_a[k]];
      lane_ok[k] = run;
      lane_idx[k*TW +: TW] = idx_a[k];
    end
    retire_n = RNW'(rob_pkg::count_bits(int'(lane_ok), LANES));
  end

  // R5: lanes form a run starting at lane 0
  p_lane_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_ok & LANES'(lane_ok + LANES'(1))) == '0);
  // R4: never retire more than is held
  p_retire_le_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retire_n) <= int'(count));
endmodule

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
  parameter int NREG  = rob_pkg::ROB_NREG,
  parameter int DEPTH = rob_pkg::ROB_DEPTH,
  parameter int NLOOK = 2,
  localparam int RW   = $clog2(NREG),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                set_en,
  input  logic [RW-1:0]       set_reg,
  input  logic [TW-1:0]       set_tag,
  input  logic [DEPTH-1:0]    retiring,
  input  logic [NLOOK*RW-1:0] lk_reg,
  output logic [NLOOK-1:0]    lk_pend,
  output logic [NLOOK*TW-1:0] lk_tag
);
  logic [NREG-1:0] map_v;
  logic [TW-1:0]   map_t [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_v <= '0;
      for (int r = 0; r < NREG; r++) map_t[r] <= '0;
    end else if (flush) begin
      map_v <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (map_v[r] && retiring[map_t[r]]) map_v[r] <= 1'b0;
        if (set_en && set_reg == RW'(r)) begin
          map_v[r] <= 1'b1;
          map_t[r] <= set_tag;
        end
      end
    end
  end

  for (genvar g = 0; g < NLOOK; g++) begin : g_look
    logic [RW-1:0] rsel;
    assign rsel = lk_reg[g*RW +: RW];
    assign lk_pend[g] = map_v[rsel] && !retiring[map_t[rsel]];
    assign lk_tag[g*TW +: TW] = map_t[rsel];
  end

  // R6: a dispatch leaves its register pointing at the new slot
  p_map_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flush) |=> (map_v[$past(set_reg)] && map_t[$past(set_reg)] == $past(set_tag)));
  // R8: flush empties the map
  p_map_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> map_v == '0);
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
  parameter int DEPTH  = rob_pkg::ROB_DEPTH,
  parameter int LANES  = rob_pkg::ROB_LANES,
  parameter int NREG   = rob_pkg::ROB_NREG,
  parameter int DATA_W = rob_pkg::ROB_DATA_W,
  localparam int TW    = $clog2(DEPTH),
  localparam int RW    = $clog2(NREG),
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int RNW   = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    disp_valid,
  input  logic [RW-1:0]           disp_dest,
  output logic                    disp_ready,
  output logic [TW-1:0]           disp_tag,
  input  logic [RW-1:0]           src_a_reg,
  output logic                    src_a_pend,
  output logic [TW-1:0]           src_a_tag,
  input  logic [RW-1:0]           src_b_reg,
  output logic                    src_b_pend,
  output logic [TW-1:0]           src_b_tag,
  input  logic                    cmpl_valid,
  input  logic [TW-1:0]           cmpl_tag,
  input  logic [DATA_W-1:0]       cmpl_data,
  output logic [LANES-1:0]        cmt_valid,
  output logic [LANES*RW-1:0]     cmt_reg,
  output logic [LANES*DATA_W-1:0] cmt_data,
  output logic                    rob_empty,
  output logic                    rob_full
);
  logic [TW-1:0]     head, tail;
  logic [CNTW-1:0]   count;
  logic [DEPTH-1:0]  ent_valid, ent_done;
  logic [RW-1:0]     ent_dest [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];

  // named internal events
  logic              disp_fire;
  logic              cmpl_hit;
  logic [LANES-1:0]  lane_ok;
  logic [LANES*TW-1:0] lane_idx;
  logic [RNW-1:0]    retire_n;
  logic [DEPTH-1:0]  retiring;

  assign rob_empty  = (count == '0);
  assign rob_full   = (count == CNTW'(DEPTH));
  assign disp_ready = !rob_full && !flush;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_tag   = tail;
  assign cmpl_hit   = cmpl_valid && ent_valid[cmpl_tag];

  rob_retire_scan #(.DEPTH(DEPTH), .LANES(LANES)) u_scan (
    .clk(clk), .rst_n(rst_n), .kill(flush), .head(head), .count(count),
    .done_vec(ent_done & ent_valid), .lane_ok(lane_ok), .lane_idx(lane_idx),
    .retire_n(retire_n)
  );

  always_comb begin
    retiring = '0;
    for (int k = 0; k < LANES; k++)
      if (lane_ok[k]) retiring[lane_idx[k*TW +: TW]] = 1'b1;
  end

  rob_rename_map #(.NREG(NREG), .DEPTH(DEPTH), .NLOOK(2)) u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .set_en(disp_fire), .set_reg(disp_dest), .set_tag(tail),
    .retiring(retiring),
    .lk_reg({src_b_reg, src_a_reg}),
    .lk_pend({src_b_pend, src_a_pend}),
    .lk_tag({src_b_tag, src_a_tag})
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [TW-1:0] sel;
    assign sel = lane_idx[k*TW +: TW];
    assign cmt_valid[k] = lane_ok[k];
    assign cmt_reg[k*RW +: RW] = ent_dest[sel];
    assign cmt_data[k*DATA_W +: DATA_W] = ent_data[sel];
  end

  // control state: completion, then retire, then allocate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; count <= '0;
      ent_valid <= '0; ent_done <= '0;
    end else if (flush) begin
      head <= '0; tail <= '0; count <= '0;
      ent_valid <= '0; ent_done <= '0;
    end else begin
      if (cmpl_hit) ent_done[cmpl_tag] <= 1'b1;
      for (int e = 0; e < DEPTH; e++)
        if (retiring[e]) begin
          ent_valid[e] <= 1'b0;
          ent_done[e]  <= 1'b0;
        end
      if (disp_fire) begin
        ent_valid[tail] <= 1'b1;
        ent_done[tail]  <= 1'b0;
      end
      head  <= TW'(rob_pkg::wrap_add(int'(head), int'(retire_n), DEPTH));
      tail  <= TW'(rob_pkg::wrap_add(int'(tail), int'(disp_fire), DEPTH));
      count <= count + CNTW'(disp_fire) - CNTW'(retire_n);
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (disp_fire) ent_dest[tail] <= disp_dest;
    if (cmpl_hit && !flush) ent_data[cmpl_tag] <= cmpl_data;
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full |-> !disp_ready);
  p_alloc_fresh_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> (ent_valid[$past(tail)] && !ent_done[$past(tail)]));
  p_cmt_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid[0] |-> (ent_valid[head] && ent_done[head]));
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rob_empty && cmt_valid == '0));
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> cmt_valid == '0);
endmodule

// File: tb/sim_reorder_buffer.sv
module sim_reorder_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 9;
  // table: dispatch valid/dest, completion valid/tag/data, expected tag, commit count, lane0 reg/data
  localparam int T_DV[NSTEP] = '{1, 1, 1, 1, 0, 0, 0, 0, 0};
  localparam int T_DD[NSTEP] = '{1, 2, 3, 1, 0, 0, 0, 0, 0};
  localparam int T_CV[NSTEP] = '{0, 0, 0, 1, 1, 1, 0, 1, 0};
  localparam int T_CT[NSTEP] = '{0, 0, 0, 2, 1, 0, 0, 3, 0};
  localparam int T_CD[NSTEP] = '{0, 0, 0, 'h22, 'h11, 'h10, 0, 'h33, 0};
  localparam int T_ET[NSTEP] = '{0, 1, 2, 3, -1, -1, -1, -1, -1};
  localparam int T_EN[NSTEP] = '{0, 0, 0, 0, 0, 0, 3, 0, 1};
  localparam int T_ER[NSTEP] = '{0, 0, 0, 0, 0, 0, 1, 0, 1};
  localparam int T_ED[NSTEP] = '{0, 0, 0, 0, 0, 0, 'h10, 0, 'h33};

  logic clk = 0, rst_n = 0, flush = 0;
  logic disp_valid = 0; logic [2:0] disp_dest = 0;
  logic disp_ready; logic [3:0] disp_tag;
  logic [2:0] src_a_reg = 0, src_b_reg = 0;
  logic src_a_pend, src_b_pend; logic [3:0] src_a_tag, src_b_tag;
  logic cmpl_valid = 0; logic [3:0] cmpl_tag = 0; logic [15:0] cmpl_data = 0;
  logic [3:0] cmt_valid; logic [11:0] cmt_reg; logic [63:0] cmt_data;
  logic rob_empty, rob_full;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_buffer u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit dv, input int dd, input bit cv, input int ct, input int cd, input bit fl);
    @(negedge clk);
    disp_valid = dv; disp_dest = 3'(dd);
    cmpl_valid = cv; cmpl_tag = 4'(ct); cmpl_data = 16'(cd);
    flush = fl;
    #1;
  endtask

  function automatic int ncmt();
    return $countones(cmt_valid);
  endfunction
  function automatic int lreg(int k);
    return int'(cmt_reg[k*3 +: 3]);
  endfunction
  function automatic int ldat(int k);
    return int'(cmt_data[k*16 +: 16]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R9 reset state
    chk(disp_ready && rob_empty && !rob_full, "R9 ready/empty", {disp_ready, rob_empty, rob_full}, 3'b110);
    chk(cmt_valid == 0, "R9 lanes", cmt_valid, 0);
    chk(!src_a_pend && !src_b_pend, "R9 lookup", {src_a_pend, src_b_pend}, 0);

    // table walk: out-of-order completion, in-order commit (R1 R3 R4)
    for (int s = 0; s < NSTEP; s++) begin
      drive(T_DV[s] != 0, T_DD[s], T_CV[s] != 0, T_CT[s], T_CD[s], 0);
      if (T_ET[s] >= 0) chk(int'(disp_tag) == T_ET[s], "R1 tag", disp_tag, T_ET[s]);
      chk(ncmt() == T_EN[s], "R4 commit count", ncmt(), T_EN[s]);
      if (T_EN[s] > 0) begin
        chk(lreg(0) == T_ER[s], "R4 lane0 reg", lreg(0), T_ER[s]);
        chk(ldat(0) == T_ED[s], "R3 lane0 data", ldat(0), T_ED[s]);
      end
    end
    drive(0, 0, 0, 0, 0, 0);
    chk(rob_empty, "R4 drained", rob_empty, 1);

    // map behaviour (R6 R7), head = tail = 4
    src_a_reg = 5;
    drive(1, 5, 0, 0, 0, 0);
    chk(disp_tag == 4, "R1 tag", disp_tag, 4);
    drive(0, 0, 0, 0, 0, 0);
    chk(src_a_pend && src_a_tag == 4, "R6 lookup", {src_a_pend, src_a_tag}, 5'h14);
    drive(1, 5, 0, 0, 0, 0);
    chk(disp_tag == 5, "R1 tag", disp_tag, 5);
    chk(src_a_pend && src_a_tag == 4, "R6 same-cycle old map", {src_a_pend, src_a_tag}, 5'h14);
    drive(0, 0, 1, 4, 'h44, 0);
    chk(src_a_pend && src_a_tag == 5, "R6 newest writer", {src_a_pend, src_a_tag}, 5'h15);
    drive(0, 0, 0, 0, 0, 0);
    chk(ncmt() == 1 && lreg(0) == 5 && ldat(0) == 'h44, "R4 commit slot4", ldat(0), 'h44);
    chk(src_a_pend && src_a_tag == 5, "R7 map kept", {src_a_pend, src_a_tag}, 5'h15);
    drive(0, 0, 1, 5, 'h55, 0);
    drive(0, 0, 0, 0, 0, 0);
    chk(ncmt() == 1 && ldat(0) == 'h55, "R4 commit slot5", ldat(0), 'h55);
    chk(!src_a_pend, "R7 retiring bypass", src_a_pend, 0);
    drive(0, 0, 0, 0, 0, 0);
    chk(!src_a_pend && rob_empty, "R7 map cleared", src_a_pend, 0);

    // fill, refuse, wide drain (R1 R2 R5), head = tail = 6
    for (int i = 0; i < 16; i++) begin
      drive(1, i % 8, 0, 0, 0, 0);
      chk(disp_ready && int'(disp_tag) == (6 + i) % 16, "R1 wrap tag", disp_tag, (6 + i) % 16);
    end
    drive(1, 7, 0, 0, 0, 0);
    chk(!disp_ready && rob_full, "R2 full refuse", {disp_ready, rob_full}, 1);
    for (int i = 0; i < 16; i++) begin
      drive(0, 0, 1, (21 - i) % 16, 'h100 + (21 - i) % 16, 0);
      chk(ncmt() == 0, "R4 head not done", ncmt(), 0);
    end
    for (int c = 0; c < 4; c++) begin
      drive(0, 0, 0, 0, 0, 0);
      chk(ncmt() == 4 && cmt_valid == 4'hF, "R5 width cap", cmt_valid, 4'hF);
      for (int k = 0; k < 4; k++)
        chk(ldat(k) == 'h100 + (6 + 4*c + k) % 16 && lreg(k) == (4*c + k) % 8,
            "R4 lane order", ldat(k), 'h100 + (6 + 4*c + k) % 16);
    end
    drive(0, 0, 0, 0, 0, 0);
    chk(rob_empty && ncmt() == 0 && disp_ready, "R2 refused dispatch absent", rob_empty, 1);

    // flush against pending commit (R8), head = tail = 6
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 2, 0, 0, 0, 0);
    drive(1, 3, 0, 0, 0, 0);
    drive(0, 0, 1, 7, 'h77, 0);
    drive(0, 0, 1, 6, 'h66, 0);
    chk(ncmt() == 0, "R4 gap at head", ncmt(), 0);
    drive(0, 0, 0, 0, 0, 1);
    chk(cmt_valid == 0, "R8 lanes quiet", cmt_valid, 0);
    chk(!disp_ready, "R2 ready low in flush", disp_ready, 0);
    src_a_reg = 1; src_b_reg = 2;
    drive(1, 4, 0, 0, 0, 0);
    chk(!src_a_pend && !src_b_pend, "R8 map clear", {src_a_pend, src_b_pend}, 0);
    chk(disp_tag == 0, "R8 tag restart", disp_tag, 0);
    src_a_reg = 4;
    drive(0, 0, 0, 0, 0, 0);
    chk(ncmt() == 0 && src_a_pend && src_a_tag == 0, "R8 post-flush map", {src_a_pend, src_a_tag}, 5'h10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule